// File: doc/BRIEF.md
# Time-Stamp Counter Event Unit

A 32-bit counter advances by one on every clock while the unit is enabled. Several sources can each stamp the counter value into a 16-entry event queue: a software capture command, the counter's own full wrap and half wrap, a hardware capture strobe, and receive and transmit strobes from an Ethernet port. The receive and transmit strobes carry a 16-bit PTP sequence ID and a 4-bit PTP message type. A host reads the queue over a simple 32-bit register bus. It reads the stamp and the descriptor word of the oldest entry, then discards that entry with a pop command. An interrupt line shows that the queue holds at least one event.

The counter reports its own wraps into the same queue as the packet events. A host that keeps an upper word in software can therefore extend every 32-bit capture into a wider time base. The half-wrap marker tells the host whether a capture near a wrap belongs before or after that wrap. The host sets the count with a load command. Events raised in the same cycle enter the queue one per cycle in a fixed priority order.

Top module: `tsc_event_unit`

## Requirements
- R1: After reset, offset 0x00 reads 0x4E8A0101. The control (0x04), raw status (0x20), masked status (0x24), event stamp (0x34) and event descriptor (0x38) registers read 0, and irq_o is low.
- R2: While control bit 0 (enable) is 1, the count increases by one each clock. While it is 0, the count holds. Writing 1 to bit 0 of offset 0x14 copies the load-value register (0x10) into the count on that edge. A load takes precedence over the increment and works whether or not the unit is enabled.
- R3: Writing 1 to bit 0 of offset 0x0C queues an event of type 0 that carries the count of the cycle in which the write occurs. The write is ignored while the unit is disabled.
- R4: An increment from 0xFFFFFFFF to 0 queues a type 1 event with stamp 0. An increment from 0x7FFFFFFF to 0x80000000 queues a type 2 event with stamp 0x80000000. A load never raises either event.
- R5: While the unit is enabled, a high hw_push_i queues a type 3 event, a high rx_stb_i queues a type 4 event and a high tx_stb_i queues a type 5 event. Each carries the count of the strobe cycle. While the unit is disabled, the strobes are ignored.
- R6: The descriptor word at 0x38 holds the event type in bits 23:20. For type 4 and type 5 it also holds the PTP message type in bits 19:16 and the PTP sequence ID in bits 15:0. All other bits read zero. Offset 0x34 returns the stamp of the oldest entry. Entries leave the queue in the order they were stored, and both registers read 0 while the queue is empty.
- R7: Writing 1 to bit 0 of offset 0x30 removes the oldest entry. A pop on an empty queue changes nothing.
- R8: Raw status bit 0 (0x20) is 1 exactly when the queue is not empty. Masked status bit 0 (0x24) is the raw bit ANDed with bit 0 of the interrupt-enable register (0x28). irq_o equals the masked bit.
- R9: Events raised on the same edge are stored one per cycle, in this priority: full wrap, half wrap, software push, hardware push, receive, transmit. A held event keeps the stamp it had when it was raised. The only event of an idle unit sets raw status after the next edge.
- R10: The queue holds 16 entries. An event offered while the queue is full is discarded and sets control bit 1. An event raised by a source whose previous event is still waiting is also discarded and also sets control bit 1. That bit stays set until a control write with bit 1 equal to 1 clears it.
- R11: Offset 0x08 stores bits 4:0 of a write and reads them back. Offsets without a register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counting reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| hw_push_i | input | 1 | Hardware capture strobe |
| rx_stb_i | input | 1 | Receive event strobe |
| rx_seq_i | input | 16 | Receive PTP sequence ID |
| rx_msg_i | input | 4 | Receive PTP message type |
| tx_stb_i | input | 1 | Transmit event strobe |
| tx_seq_i | input | 16 | Transmit PTP sequence ID |
| tx_msg_i | input | 4 | Transmit PTP message type |
| irq_o | output | 1 | Event-pending interrupt |

## Verification
The hardest coincidence is a counter wrap that lands on the same edge as a software push and all three strobes. The bench provokes it by loading a value just below the wrap. It watches its reference count and fires every source on the edge where that count reads 0xFFFFFFFF. It then drains five entries and judges both their order and their stamps: the wrap carries 0 and the others carry 0xFFFFFFFF. A second coincidence is a source raised again while its earlier event still waits behind a higher-priority source. The bench provokes it by holding receive and transmit high together for two cycles and expects the overflow bit and the queue contents its model predicts.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int CNT_W = 32;
  localparam int NSRC  = 6;

  // Source index doubles as arbitration priority (lower index wins)
  localparam int SRC_WRAP = 0;
  localparam int SRC_HALF = 1;
  localparam int SRC_PUSH = 2;
  localparam int SRC_HWP  = 3;
  localparam int SRC_RX   = 4;
  localparam int SRC_TX   = 5;

  typedef struct packed {
    logic [3:0]       kind;
    logic [3:0]       msg;
    logic [15:0]      seq;
    logic [CNT_W-1:0] stamp;
  } tsc_evt_t;

  localparam logic [7:0] OFS_IDENT  = 8'h00;
  localparam logic [7:0] OFS_CTRL   = 8'h04;
  localparam logic [7:0] OFS_REFSEL = 8'h08;
  localparam logic [7:0] OFS_PUSH   = 8'h0C;
  localparam logic [7:0] OFS_LDVAL  = 8'h10;
  localparam logic [7:0] OFS_LDEN   = 8'h14;
  localparam logic [7:0] OFS_RAW    = 8'h20;
  localparam logic [7:0] OFS_MASKED = 8'h24;
  localparam logic [7:0] OFS_INTEN  = 8'h28;
  localparam logic [7:0] OFS_POP    = 8'h30;
  localparam logic [7:0] OFS_EVLO   = 8'h34;
  localparam logic [7:0] OFS_EVHI   = 8'h38;

  // Type code stored for each source
  function automatic logic [3:0] kind_of(input int src);
    case (src)
      SRC_WRAP: return 4'd1;
      SRC_HALF: return 4'd2;
      SRC_PUSH: return 4'd0;
      SRC_HWP:  return 4'd3;
      SRC_RX:   return 4'd4;
      SRC_TX:   return 4'd5;
      default:  return 4'd0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] wrap_stamp();
    return '0;
  endfunction

  function automatic logic [CNT_W-1:0] half_stamp();
    return {1'b1, {(CNT_W-1){1'b0}}};
  endfunction

  function automatic logic [31:0] pack_high(input tsc_evt_t e);
    return {8'h00, e.kind, e.msg, e.seq};
  endfunction
endpackage

// File: rtl/tsc_counter.sv
module tsc_counter
  import tsc_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap_ev,
  output logic         half_ev
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] MID = TOP >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (en)   cnt <= cnt + 1'b1;
  end

  // Transitions caused by the increment only; a load suppresses both
  always_comb begin
    wrap_ev = en & ~load & (cnt == TOP);
    half_ev = en & ~load & (cnt == MID);
  end
endmodule

// File: rtl/tsc_evt_arb.sv
module tsc_evt_arb
  import tsc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         raise,
  input  tsc_evt_t [N-1:0]     ev_in,
  output logic                 out_valid,
  output tsc_evt_t             out_evt,
  output logic [N-1:0]         grant,
  output logic [N-1:0]         held_v,
  output logic                 collide
);
  tsc_evt_t [N-1:0] held_d;
  logic [N-1:0]     coll;

  function automatic logic [N-1:0] first_set(input logic [N-1:0] v);
    logic [N-1:0] r;
    logic         seen;
    r    = '0;
    seen = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (v[k] && !seen) begin
        r[k] = 1'b1;
        seen = 1'b1;
      end
    end
    return r;
  endfunction

  assign grant = first_set(held_v);

  generate
    for (genvar i = 0; i < N; i++) begin : g_slot
      logic     v_q;
      tsc_evt_t d_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else begin
          v_q <= (v_q & ~grant[i]) | raise[i];
          if (raise[i] && (!v_q || grant[i])) d_q <= ev_in[i];
        end
      end
      assign held_v[i] = v_q;
      assign held_d[i] = d_q;
      assign coll[i]   = raise[i] & v_q & ~grant[i];
    end
  endgenerate

  always_comb begin
    out_evt = '0;
    for (int k = 0; k < N; k++) begin
      if (grant[k]) out_evt = out_evt | held_d[k];
    end
  end

  assign out_valid = |held_v;
  assign collide   = |coll;
endmodule

// File: rtl/tsc_evt_fifo.sv
module tsc_evt_fifo
  import tsc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  tsc_evt_t      din,
  input  logic          pop,
  output tsc_evt_t      head,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          drop,
  output logic [LW-1:0] level
);
  localparam int AW = $clog2(DEPTH);

  tsc_evt_t        mem [DEPTH];
  logic [AW-1:0]   wr_ptr;
  logic [AW-1:0]   rd_ptr;
  logic            full;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push & ~full;
  assign drop    = push & full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end
endmodule

// File: rtl/tsc_event_unit.sv
module tsc_event_unit
  import tsc_pkg::*;
#(
  parameter int          FIFO_DEPTH = 16,
  parameter int          REFSEL_W   = 5,
  parameter logic [31:0] ID_VALUE   = 32'h4E8A_0101
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        hw_push_i,
  input  logic        rx_stb_i,
  input  logic [15:0] rx_seq_i,
  input  logic [3:0]  rx_msg_i,
  input  logic        tx_stb_i,
  input  logic [15:0] tx_seq_i,
  input  logic [3:0]  tx_msg_i,
  output logic        irq_o
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic                en_q, ovf_q, inten_q;
  logic [REFSEL_W-1:0] refsel_q;
  logic [CNT_W-1:0]    loadval_q;
  logic [CNT_W-1:0]    cnt_q;

  // Named internal events, also observed by the bound checker
  logic                push_cmd, load_cmd, pop_cmd, ctrl_wr;
  logic                wrap_ev, half_ev;
  logic [NSRC-1:0]     raise;
  tsc_evt_t [NSRC-1:0] ev_in;
  logic                arb_valid, arb_collide;
  tsc_evt_t            arb_evt;
  logic [NSRC-1:0]     arb_grant, slot_v;
  tsc_evt_t            fifo_head;
  logic                fifo_empty, fifo_push_ok, fifo_pop_ok, fifo_drop;
  logic [LVL_W-1:0]    fifo_level;
  logic                raw_st, masked_st;

  function automatic logic wr_hit(input logic we, input logic [7:0] a,
                                  input logic [7:0] ofs);
    return we && (a == ofs);
  endfunction

  assign ctrl_wr  = wr_hit(bus_we, bus_addr, OFS_CTRL);
  assign push_cmd = wr_hit(bus_we, bus_addr, OFS_PUSH) & bus_wdata[0];
  assign load_cmd = wr_hit(bus_we, bus_addr, OFS_LDEN) & bus_wdata[0];
  assign pop_cmd  = wr_hit(bus_we, bus_addr, OFS_POP)  & bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      inten_q   <= 1'b0;
      refsel_q  <= '0;
      loadval_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_CTRL:   en_q      <= bus_wdata[0];
        OFS_INTEN:  inten_q   <= bus_wdata[0];
        OFS_REFSEL: refsel_q  <= bus_wdata[REFSEL_W-1:0];
        OFS_LDVAL:  loadval_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ovf_q <= 1'b0;
    else if (fifo_drop || arb_collide)  ovf_q <= 1'b1;
    else if (ctrl_wr && bus_wdata[1])   ovf_q <= 1'b0;
  end

  tsc_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .load     (load_cmd),
    .load_val (loadval_q),
    .cnt      (cnt_q),
    .wrap_ev  (wrap_ev),
    .half_ev  (half_ev)
  );

  always_comb begin
    raise           = '0;
    raise[SRC_WRAP] = wrap_ev;
    raise[SRC_HALF] = half_ev;
    raise[SRC_PUSH] = en_q & push_cmd;
    raise[SRC_HWP]  = en_q & hw_push_i;
    raise[SRC_RX]   = en_q & rx_stb_i;
    raise[SRC_TX]   = en_q & tx_stb_i;
    for (int s = 0; s < NSRC; s++) begin
      ev_in[s].kind  = kind_of(s);
      ev_in[s].msg   = '0;
      ev_in[s].seq   = '0;
      ev_in[s].stamp = cnt_q;
    end
    ev_in[SRC_WRAP].stamp = wrap_stamp();
    ev_in[SRC_HALF].stamp = half_stamp();
    ev_in[SRC_RX].msg     = rx_msg_i;
    ev_in[SRC_RX].seq     = rx_seq_i;
    ev_in[SRC_TX].msg     = tx_msg_i;
    ev_in[SRC_TX].seq     = tx_seq_i;
  end

  tsc_evt_arb #(.N(NSRC)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise     (raise),
    .ev_in     (ev_in),
    .out_valid (arb_valid),
    .out_evt   (arb_evt),
    .grant     (arb_grant),
    .held_v    (slot_v),
    .collide   (arb_collide)
  );

  tsc_evt_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (arb_valid),
    .din     (arb_evt),
    .pop     (pop_cmd),
    .head    (fifo_head),
    .empty   (fifo_empty),
    .push_ok (fifo_push_ok),
    .pop_ok  (fifo_pop_ok),
    .drop    (fifo_drop),
    .level   (fifo_level)
  );

  assign raw_st    = ~fifo_empty;
  assign masked_st = raw_st & inten_q;
  assign irq_o     = masked_st;

  always_comb begin
    case (bus_addr)
      OFS_IDENT:  bus_rdata = ID_VALUE;
      OFS_CTRL:   bus_rdata = {30'b0, ovf_q, en_q};
      OFS_REFSEL: bus_rdata = {{(32-REFSEL_W){1'b0}}, refsel_q};
      OFS_LDVAL:  bus_rdata = loadval_q;
      OFS_RAW:    bus_rdata = {31'b0, raw_st};
      OFS_MASKED: bus_rdata = {31'b0, masked_st};
      OFS_INTEN:  bus_rdata = {31'b0, inten_q};
      OFS_EVLO:   bus_rdata = fifo_empty ? 32'h0 : fifo_head.stamp;
      OFS_EVHI:   bus_rdata = fifo_empty ? 32'h0 : pack_high(fifo_head);
      default:    bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/tsc_event_unit_chk.sv
module tsc_event_unit_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic          load_cmd,
  input logic [31:0]   cnt_q,
  input logic          wrap_ev,
  input logic          half_ev,
  input logic [5:0]    slot_v,
  input logic [5:0]    arb_grant,
  input logic          fifo_drop,
  input logic          ovf_q,
  input logic          fifo_push_ok,
  input logic          fifo_pop_ok,
  input logic [LW-1:0] fifo_level,
  input logic          irq_o
);
  assert_grant_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_grant));

  assert_drop_sets_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |=> ovf_q);

  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (cnt_q == 32'h0) && slot_v[0]);

  assert_half_queued_R4: assert property (@(posedge clk) disable iff (!rst_n)
    half_ev |=> cnt_q[31] && slot_v[1]);

  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !load_cmd) |=> $stable(cnt_q));

  assert_last_pop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop_ok && !fifo_push_ok && fifo_level == LW'(1)) |=> !irq_o);

  always @(posedge clk) begin
    if (rst_n) begin
      assert_level_bound_R10: assert (fifo_level <= LW'(DEPTH))
        else $error("queue level above depth");
    end
  end
endmodule

bind tsc_event_unit tsc_event_unit_chk #(.DEPTH(FIFO_DEPTH), .LW(LVL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_q         (en_q),
  .load_cmd     (load_cmd),
  .cnt_q        (cnt_q),
  .wrap_ev      (wrap_ev),
  .half_ev      (half_ev),
  .slot_v       (slot_v),
  .arb_grant    (arb_grant),
  .fifo_drop    (fifo_drop),
  .ovf_q        (ovf_q),
  .fifo_push_ok (fifo_push_ok),
  .fifo_pop_ok  (fifo_pop_ok),
  .fifo_level   (fifo_level),
  .irq_o        (irq_o)
);

// File: tb/tsc_event_unit_bench.sv
module tsc_event_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_we = 1'b0;
  logic [7:0]  b_addr = 8'h0;
  logic [31:0] b_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        hw = 1'b0, rx = 1'b0, tx = 1'b0;
  logic [15:0] rxseq = 16'h0, txseq = 16'h0;
  logic [3:0]  rxmsg = 4'h0, txmsg = 4'h0;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit live   = 1'b0;

  always #4 clk = ~clk;

  tsc_event_unit u_tsc_event_unit (
    .clk(clk), .rst_n(rst_n), .bus_we(b_we), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(bus_rdata), .hw_push_i(hw),
    .rx_stb_i(rx), .rx_seq_i(rxseq), .rx_msg_i(rxmsg),
    .tx_stb_i(tx), .tx_seq_i(txseq), .tx_msg_i(txmsg), .irq_o(irq_o)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cnt, m_loadval;
  logic [4:0]  m_refsel;
  bit          m_en, m_ovf, m_inten;
  bit          m_sv [6];
  logic [55:0] m_sd [6];
  logic [55:0] m_q [$];

  function automatic logic [55:0] mk(input int kind, input logic [3:0] msg,
                                     input logic [15:0] seq, input logic [31:0] st);
    return {kind[3:0], msg, seq, st};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_loadval = 0; m_refsel = 0;
      m_en = 0; m_ovf = 0; m_inten = 0;
      foreach (m_sv[k]) begin m_sv[k] = 0; m_sd[k] = 0; end
      m_q.delete();
    end else begin
      bit push_c, load_c, pop_c, drop, coll, isfull;
      bit rs [6];
      logic [55:0] nd [6];
      int g;
      push_c = b_we && b_addr == 8'h0C && b_wdata[0];
      load_c = b_we && b_addr == 8'h14 && b_wdata[0];
      pop_c  = b_we && b_addr == 8'h30 && b_wdata[0];
      rs[0] = m_en && !load_c && m_cnt == 32'hFFFF_FFFF;
      rs[1] = m_en && !load_c && m_cnt == 32'h7FFF_FFFF;
      rs[2] = m_en && push_c;
      rs[3] = m_en && hw;
      rs[4] = m_en && rx;
      rs[5] = m_en && tx;
      nd[0] = mk(1, 0, 0, 32'h0);
      nd[1] = mk(2, 0, 0, 32'h8000_0000);
      nd[2] = mk(0, 0, 0, m_cnt);
      nd[3] = mk(3, 0, 0, m_cnt);
      nd[4] = mk(4, rxmsg, rxseq, m_cnt);
      nd[5] = mk(5, txmsg, txseq, m_cnt);
      g = -1;
      for (int k = 5; k >= 0; k--) if (m_sv[k]) g = k;
      isfull = (m_q.size() >= 16);
      drop = 0; coll = 0;
      if (pop_c && m_q.size() > 0) void'(m_q.pop_front());
      if (g >= 0) begin
        if (isfull) drop = 1; else m_q.push_back(m_sd[g]);
        m_sv[g] = 0;
      end
      for (int k = 0; k < 6; k++) begin
        if (rs[k]) begin
          if (m_sv[k]) coll = 1;
          else begin m_sv[k] = 1; m_sd[k] = nd[k]; end
        end
      end
      if (drop || coll) m_ovf = 1;
      else if (b_we && b_addr == 8'h04 && b_wdata[1]) m_ovf = 0;
      if (load_c) m_cnt = m_loadval;
      else if (m_en) m_cnt = m_cnt + 1;
      if (b_we) begin
        case (b_addr)
          8'h04: m_en = b_wdata[0];
          8'h28: m_inten = b_wdata[0];
          8'h08: m_refsel = b_wdata[4:0];
          8'h10: m_loadval = b_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return 32'h4E8A_0101;
      8'h04: return {30'b0, m_ovf, m_en};
      8'h08: return {27'b0, m_refsel};
      8'h10: return m_loadval;
      8'h20: return {31'b0, m_q.size() != 0};
      8'h24: return {31'b0, (m_q.size() != 0) && m_inten};
      8'h28: return {31'b0, m_inten};
      8'h34: return (m_q.size() != 0) ? m_q[0][31:0] : 32'h0;
      8'h38: return (m_q.size() != 0) ? {8'h0, m_q[0][55:32]} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Interrupt line against the model on every cycle (R8)
  always @(negedge clk) begin
    if (live) chk({31'b0, irq_o}, {31'b0, (m_q.size() != 0) && m_inten}, "R8 irq per cycle");
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    b_we = 1; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_we = 0; b_addr = 8'h00; b_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, output logic [31:0] v);
    @(negedge clk);
    b_addr = a;
    #1;
    v = bus_rdata;
    chk(v, exp_rd(a), tag);
  endtask

  task automatic rdm(input logic [7:0] a, input string tag);
    logic [31:0] v;
    rd(a, tag, v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    while (m_q.size() != 0) begin
      rdm(8'h34, tag);
      rdm(8'h38, tag);
      wr(8'h30, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;

    // R1 reset state
    rd(8'h00, "R1 ident", v);
    chk(v, 32'h4E8A_0101, "R1 ident literal");
    rdm(8'h04, "R1 control");
    rdm(8'h20, "R1 raw");
    rdm(8'h24, "R1 masked");
    rdm(8'h34, "R1 stamp");
    rdm(8'h38, "R1 descriptor");

    // R11 plain register and unmapped offset
    wr(8'h08, 32'hFFFF_FF15);
    rd(8'h08, "R11 refsel", v);
    chk(v, 32'h15, "R11 refsel literal");
    rdm(8'h18, "R11 unmapped");

    // R3 software push while disabled is ignored
    wr(8'h0C, 1);
    idle(3);
    rdm(8'h20, "R3 push ignored when off");

    wr(8'h04, 1);
    wr(8'h28, 1);

    // R3 software push
    wr(8'h0C, 1);
    idle(3);
    rd(8'h20, "R3 raw after push", v);
    chk(v, 32'h1, "R3 raw literal");
    rdm(8'h34, "R3 stamp");
    rd(8'h38, "R3 descriptor", v);
    chk(v, 32'h0, "R3 type 0 literal");
    wr(8'h30, 1);
    rdm(8'h20, "R7 raw after pop");

    // R2 load then push; disable holds the count
    wr(8'h10, 32'h0000_1000);
    wr(8'h14, 1);
    wr(8'h0C, 1);
    idle(3);
    rdm(8'h34, "R2 stamp after load");
    wr(8'h30, 1);
    wr(8'h04, 0);
    wr(8'h14, 1);
    hw = 1; idle(1); hw = 0;
    idle(10);
    rdm(8'h20, "R5 strobe ignored when off");
    wr(8'h04, 1);
    wr(8'h0C, 1);
    idle(3);
    rdm(8'h34, "R2 count held while off");
    wr(8'h30, 1);

    // R4 half wrap and full wrap
    wr(8'h10, 32'h7FFF_FFF0);
    wr(8'h14, 1);
    idle(25);
    rd(8'h34, "R4 half stamp", v);
    chk(v, 32'h8000_0000, "R4 half stamp literal");
    rd(8'h38, "R4 half descriptor", v);
    chk(v, 32'h0020_0000, "R4 half type literal");
    wr(8'h30, 1);
    wr(8'h10, 32'hFFFF_FFF0);
    wr(8'h14, 1);
    idle(25);
    rd(8'h34, "R4 wrap stamp", v);
    chk(v, 32'h0, "R4 wrap stamp literal");
    rd(8'h38, "R4 wrap descriptor", v);
    chk(v, 32'h0010_0000, "R4 wrap type literal");
    drain("R4 drain");

    // R5 / R6 strobes with PTP fields
    rxseq = 16'h1234; rxmsg = 4'h3; rx = 1; idle(1); rx = 0;
    idle(2);
    txseq = 16'hABCD; txmsg = 4'h1; tx = 1; idle(1); tx = 0;
    hw = 1; idle(1); hw = 0;
    idle(4);
    rd(8'h38, "R6 rx descriptor", v);
    chk(v, 32'h0043_1234, "R6 rx descriptor literal");
    drain("R5 strobe order");

    // R9 coincident wrap, push and all strobes
    wr(8'h10, 32'hFFFF_FFF0);
    wr(8'h14, 1);
    while (m_cnt != 32'hFFFF_FFFF) @(negedge clk);
    b_we = 1; b_addr = 8'h0C; b_wdata = 1;
    hw = 1; rx = 1; rxseq = 16'h0007; rxmsg = 4'h2;
    tx = 1; txseq = 16'h0009; txmsg = 4'h4;
    @(negedge clk);
    b_we = 0; b_addr = 0; b_wdata = 0; hw = 0; rx = 0; tx = 0;
    idle(8);
    begin
      int kinds [5] = '{1, 0, 3, 4, 5};
      for (int i = 0; i < 5; i++) begin
        rd(8'h38, "R9 order", v);
        chk({28'b0, v[23:20]}, kinds[i], "R9 order literal");
        rd(8'h34, "R9 stamp", v);
        chk(v, (i == 0) ? 32'h0 : 32'hFFFF_FFFF, "R9 stamp literal");
        wr(8'h30, 1);
      end
    end

    // R7 pop on empty queue
    wr(8'h30, 1);
    rdm(8'h20, "R7 empty pop raw");
    rdm(8'h34, "R7 empty pop stamp");

    // R8 masking
    wr(8'h28, 0);
    wr(8'h0C, 1);
    idle(3);
    rdm(8'h20, "R8 raw with mask off");
    rd(8'h24, "R8 masked with mask off", v);
    chk(v, 32'h0, "R8 masked literal");
    wr(8'h28, 1);
    rdm(8'h24, "R8 masked with mask on");
    wr(8'h30, 1);

    // R10 queue overflow
    for (int i = 0; i < 17; i++) wr(8'h0C, 1);
    idle(3);
    rd(8'h04, "R10 overflow flag", v);
    chk(v, 32'h3, "R10 overflow literal");
    begin
      int n = 0;
      while (m_q.size() != 0) begin
        rdm(8'h34, "R10 drain stamp");
        wr(8'h30, 1);
        n++;
      end
      chk(n, 16, "R10 stored entries");
    end
    wr(8'h04, 32'h3);
    rd(8'h04, "R10 flag cleared", v);
    chk(v, 32'h1, "R10 cleared literal");

    // R10 same-source collision while held behind a higher priority
    rxseq = 16'h0101; txseq = 16'h0202;
    rx = 1; tx = 1; idle(2); rx = 0; tx = 0;
    idle(5);
    rdm(8'h04, "R10 collision flag");
    drain("R10 collision contents");
    wr(8'h04, 32'h3);
    rdm(8'h04, "R10 collision cleared");

    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule